// File: doc/BRIEF.md
# Command-Register Peripheral-Bus Bridge

This block is a slave on a 64-bit register bus. It turns one packed command word into a single transaction on a simple on-chip peripheral bus. Firmware writes a command word that holds direction, size, a 24-bit target address and, for writes, 32 bits of data. The bridge then holds a request on the peripheral bus until the target answers with an acknowledge or an error-acknowledge, or until the bridge's own timeout expires.

Firmware polls a status word to follow the transaction. The status word carries busy, read-valid and a set of sticky error flags. Its low half holds the data of the last successful read. A second register freezes the status as it stood after the first failing transaction. Writes with bit 63 set either clear the recorded status or soft-reset the whole bridge.

The bridge also folds two 6-bit error vectors from downstream master groups into the status as sticky bits.

Top module: `regcmd_pbus_bridge`

## Requirements
- R1: After reset, every readable register returns zero and `pb_req` is low.
- R2: A command written at offset 0 while idle, with a legal size code, raises `pb_req` in the next cycle. The request carries these fields from the command word: direction from bit 63 (1 = write), size from bits 62:61 (00 byte, 01 half, 11 word), address from bits 55:32 and write data from bits 31:0. Offset 0 then reads back that command word.
- R3: Status bit 48 (busy) and `pb_req` stay high with stable request fields until the cycle in which `pb_ack` or `pb_err_ack` is seen. Both are low from the next cycle on.
- R4: A read that ends with `pb_ack` sets status bit 49 (read-valid) and places `pb_rdata` in status bits 31:0. Accepting a new command clears read-valid. A completed write leaves read-valid low and leaves bits 31:0 unchanged.
- R5: An error-acknowledge (which wins over a simultaneous acknowledge) sets status bit 52 and the summary bit 63. It does not set read-valid.
- R6: When no response arrives, the request is held for exactly TIMEOUT_CYCLES cycles and then dropped, and status bit 51 and bit 63 are set.
- R7: A command written while busy is ignored: the outstanding request and the command read-back keep their values. The bridge sets status bit 50 and bit 63.
- R8: A command with size code 10 starts no transaction and sets status bit 53 and bit 63.
- R9: Each cycle, `grp_a_err` is ORed into status bits 47:42 and `grp_b_err` into status bits 39:34. These bits are sticky, and any of them sets bit 63.
- R10: Offset 2 holds a snapshot of the status word taken right after the first failing event: bad size, collision, error-acknowledge or timeout. Later failures do not change it until the status is cleared.
- R11: A write to offset 1 with bit 63 set clears the error bits, read-valid, the read data and the snapshot. An event in the same cycle still takes effect, and busy is kept. A write to offset 1 with bit 63 clear has no effect.
- R12: A write to offset 4 with bit 63 set aborts any transaction and returns every register to its reset value. A later acknowledge then has no effect. A write to offset 4 with bit 63 clear has no effect.
- R13: Reads of unmapped offsets return zero. Writes to offset 2 or to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational on reg_addr) |
| pb_req | output | 1 | Peripheral-bus request, held until answered |
| pb_we | output | 1 | 1 = write transaction |
| pb_size | output | 2 | Transfer size code |
| pb_addr | output | 24 | Target address |
| pb_wdata | output | 32 | Write data |
| pb_ack | input | 1 | Successful completion |
| pb_err_ack | input | 1 | Error completion |
| pb_rdata | input | 32 | Read data, valid with pb_ack |
| grp_a_err | input | 6 | Error flags from downstream master group A |
| grp_b_err | input | 6 | Error flags from downstream master group B |

## Verification
The assertions check the properties that hold on every cycle. A request stays held with frozen fields while it is unanswered, and it drops after a response or a timeout. The wait counter never passes its limit. Each completion event shows up in the status in the next cycle, and the snapshot holds still once taken. Other behaviour only the bench's scenarios can show: the exact count of request cycles before a timeout, the contents of the snapshot, a collision leaving the outstanding request intact, and the register state after a soft reset or a status clear. The bench also covers randomized mixes of reads, writes, error-acknowledges and downstream error pulses.

// File: rtl/rcb_pkg.sv
package rcb_pkg;
  localparam int unsigned PB_AW = 24;
  localparam int unsigned PB_DW = 32;
  localparam int unsigned GRP_W = 6;

  localparam int unsigned OFS_CMD  = 0;
  localparam int unsigned OFS_STAT = 1;
  localparam int unsigned OFS_LAT  = 2;
  localparam int unsigned OFS_RST  = 4;

  localparam int unsigned BIT_ANY   = 31;
  localparam int unsigned BIT_BADSZ = 21;
  localparam int unsigned BIT_EACK  = 20;
  localparam int unsigned BIT_TMO   = 19;
  localparam int unsigned BIT_COLL  = 18;
  localparam int unsigned BIT_RVAL  = 17;
  localparam int unsigned BIT_BUSY  = 16;
  localparam int unsigned GRPA_LSB  = 10;
  localparam int unsigned GRPB_LSB  = 2;
  localparam int unsigned CTL_BIT   = 63;

  // all bits of the upper status half that count as an error
  localparam logic [31:0] ERR_MASK = 32'h7FFC_FCFC;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_RSVD = 2'b10,
    SZ_WORD = 2'b11
  } size_e;

  typedef struct packed {
    logic             we;
    size_e            size;
    logic [PB_AW-1:0] addr;
    logic [PB_DW-1:0] wdata;
  } xact_t;

  function automatic xact_t unpack_cmd(input logic [63:0] w);
    xact_t x;
    x.we    = w[63];
    x.size  = size_e'(w[62:61]);
    x.addr  = w[32+PB_AW-1:32];
    x.wdata = w[PB_DW-1:0];
    return x;
  endfunction

  function automatic logic size_legal(input logic [1:0] s);
    return s != SZ_RSVD;
  endfunction

  function automatic logic [31:0] err_vector(input logic bad, input logic eack,
                                             input logic tmo, input logic coll,
                                             input logic [GRP_W-1:0] ga,
                                             input logic [GRP_W-1:0] gb);
    logic [31:0] v;
    v = '0;
    v[BIT_BADSZ] = bad;
    v[BIT_EACK]  = eack;
    v[BIT_TMO]   = tmo;
    v[BIT_COLL]  = coll;
    v[GRPA_LSB +: GRP_W] = ga;
    v[GRPB_LSB +: GRP_W] = gb;
    return v;
  endfunction

  function automatic logic [31:0] status_hi(input logic [31:0] err, input logic rv,
                                            input logic busy);
    logic [31:0] h;
    h = err & ERR_MASK;
    h[BIT_RVAL] = rv;
    h[BIT_BUSY] = busy;
    h[BIT_ANY]  = |(err & ERR_MASK);
    return h;
  endfunction
endpackage

// File: rtl/rcb_cmd_decode.sv
module rcb_cmd_decode
  import rcb_pkg::*;
#(
  parameter int unsigned REG_AW = 3
) (
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  input  logic              busy,
  output logic              cmd_go,
  output logic              cmd_coll,
  output logic              cmd_bad,
  output logic              stat_clr,
  output logic              soft_rst,
  output xact_t             cmd_fields
);
  logic wr_cmd;

  always_comb begin
    cmd_fields = unpack_cmd(reg_wdata);
    wr_cmd     = reg_wr_en && (reg_addr == REG_AW'(OFS_CMD));
    cmd_coll   = wr_cmd && busy;
    cmd_go     = wr_cmd && !busy && size_legal(cmd_fields.size);
    cmd_bad    = wr_cmd && !busy && !size_legal(cmd_fields.size);
    stat_clr   = reg_wr_en && (reg_addr == REG_AW'(OFS_STAT)) && reg_wdata[CTL_BIT];
    soft_rst   = reg_wr_en && (reg_addr == REG_AW'(OFS_RST)) && reg_wdata[CTL_BIT];
  end
endmodule

// File: rtl/rcb_xact_fsm.sv
module rcb_xact_fsm
  import rcb_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             cmd_go,
  input  xact_t            cmd_fields,
  input  logic             pb_ack,
  input  logic             pb_err_ack,
  output logic             pb_req,
  output logic             pb_we,
  output logic [1:0]       pb_size,
  output logic [PB_AW-1:0] pb_addr,
  output logic [PB_DW-1:0] pb_wdata,
  output logic             busy,
  output logic             busy_nxt,
  output logic             ev_rd_ok,
  output logic             ev_err_ack,
  output logic             ev_tmo
);
  localparam int unsigned CNT_W = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  typedef enum logic {ST_IDLE, ST_WAIT} st_e;

  st_e              state_q;
  xact_t            xact_q;
  logic [CNT_W-1:0] cnt_q;
  logic             in_wait, ev_ok, finish;

  always_comb begin
    in_wait    = (state_q == ST_WAIT);
    ev_err_ack = in_wait && pb_err_ack;
    ev_ok      = in_wait && pb_ack && !pb_err_ack;
    ev_rd_ok   = ev_ok && !xact_q.we;
    ev_tmo     = in_wait && !pb_ack && !pb_err_ack && (cnt_q == CNT_LAST);
    finish     = ev_ok || ev_err_ack || ev_tmo;
    busy_nxt   = !soft_rst && (cmd_go || (in_wait && !finish));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      state_q <= ST_IDLE;
      xact_q  <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (cmd_go) begin
          state_q <= ST_WAIT;
          xact_q  <= cmd_fields;
          cnt_q   <= '0;
        end
        ST_WAIT: if (finish) state_q <= ST_IDLE;
                 else        cnt_q   <= cnt_q + 1'b1;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = in_wait;
  assign pb_req   = in_wait;
  assign pb_we    = xact_q.we;
  assign pb_size  = xact_q.size;
  assign pb_addr  = xact_q.addr;
  assign pb_wdata = xact_q.wdata;

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_req && !pb_ack && !pb_err_ack && !ev_tmo && !soft_rst)
      |=> (pb_req && $stable(pb_addr) && $stable(pb_we) && $stable(pb_wdata) && $stable(pb_size)));

  assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_req && (pb_ack || pb_err_ack)) |=> !pb_req);

  assert_tmo_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tmo |=> !pb_req);

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pb_req |-> (cnt_q <= CNT_LAST));
endmodule

// File: rtl/rcb_status.sv
module rcb_status
  import rcb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             stat_clr,
  input  logic             cmd_go,
  input  logic             cmd_coll,
  input  logic             cmd_bad,
  input  logic [63:0]      cmd_word,
  input  logic             busy,
  input  logic             busy_nxt,
  input  logic             ev_rd_ok,
  input  logic             ev_err_ack,
  input  logic             ev_tmo,
  input  logic [PB_DW-1:0] pb_rdata,
  input  logic [GRP_W-1:0] grp_a_err,
  input  logic [GRP_W-1:0] grp_b_err,
  output logic [63:0]      status_word,
  output logic [63:0]      latched_word,
  output logic [63:0]      cmd_echo
);
  logic [31:0]      err_q, err_nxt;
  logic             rv_q, rv_nxt;
  logic [PB_DW-1:0] rd_q, rd_nxt;
  logic [63:0]      lat_q, stat_nxt;
  logic             held_q, held_base, fail_ev;
  logic [63:0]      echo_q;

  always_comb begin
    err_nxt = (stat_clr ? 32'h0 : err_q)
            | err_vector(cmd_bad, ev_err_ack, ev_tmo, cmd_coll, grp_a_err, grp_b_err);
    if (cmd_go)        rv_nxt = 1'b0;
    else if (ev_rd_ok) rv_nxt = 1'b1;
    else if (stat_clr) rv_nxt = 1'b0;
    else               rv_nxt = rv_q;
    if (ev_rd_ok)      rd_nxt = pb_rdata;
    else if (stat_clr) rd_nxt = '0;
    else               rd_nxt = rd_q;
    stat_nxt  = {status_hi(err_nxt, rv_nxt, busy_nxt), rd_nxt};
    fail_ev   = cmd_bad || cmd_coll || ev_err_ack || ev_tmo;
    held_base = held_q && !stat_clr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      err_q  <= '0;
      rv_q   <= 1'b0;
      rd_q   <= '0;
      lat_q  <= '0;
      held_q <= 1'b0;
      echo_q <= '0;
    end else begin
      err_q <= err_nxt;
      rv_q  <= rv_nxt;
      rd_q  <= rd_nxt;
      if (cmd_go) echo_q <= cmd_word;
      if (fail_ev && !held_base) begin
        lat_q  <= stat_nxt;
        held_q <= 1'b1;
      end else if (stat_clr) begin
        lat_q  <= '0;
        held_q <= 1'b0;
      end
    end
  end

  assign status_word  = {status_hi(err_q, rv_q, busy), rd_q};
  assign latched_word = lat_q;
  assign cmd_echo     = echo_q;

  assert_eack_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_err_ack && !soft_rst) |=> (status_word[32+BIT_EACK] && status_word[63] && !status_word[32+BIT_RVAL]));

  assert_rd_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rd_ok && !soft_rst) |=> (status_word[32+BIT_RVAL] && status_word[31:0] == $past(pb_rdata)));

  assert_rv_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> !status_word[32+BIT_RVAL]);

  assert_tmo_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tmo && !soft_rst) |=> (status_word[32+BIT_TMO] && status_word[63]));

  assert_grp_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grp_a_err || |grp_b_err) && !soft_rst) |=> status_word[63]);

  assert_lat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !stat_clr && !soft_rst) |=> $stable(latched_word));
endmodule

// File: rtl/regcmd_pbus_bridge.sv
module regcmd_pbus_bridge
  import rcb_pkg::*;
#(
  parameter int unsigned REG_AW         = 3,
  parameter int unsigned TIMEOUT_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              pb_req,
  output logic              pb_we,
  output logic [1:0]        pb_size,
  output logic [23:0]       pb_addr,
  output logic [31:0]       pb_wdata,
  input  logic              pb_ack,
  input  logic              pb_err_ack,
  input  logic [31:0]       pb_rdata,
  input  logic [5:0]        grp_a_err,
  input  logic [5:0]        grp_b_err
);
  logic        cmd_go, cmd_coll, cmd_bad, stat_clr, soft_rst;
  xact_t       cmd_fields;
  logic        busy, busy_nxt, ev_rd_ok, ev_err_ack, ev_tmo;
  logic [63:0] status_word, latched_word, cmd_echo;

  rcb_cmd_decode #(.REG_AW(REG_AW)) u_dec (
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .cmd_go    (cmd_go),
    .cmd_coll  (cmd_coll),
    .cmd_bad   (cmd_bad),
    .stat_clr  (stat_clr),
    .soft_rst  (soft_rst),
    .cmd_fields(cmd_fields)
  );

  rcb_xact_fsm #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .cmd_go    (cmd_go),
    .cmd_fields(cmd_fields),
    .pb_ack    (pb_ack),
    .pb_err_ack(pb_err_ack),
    .pb_req    (pb_req),
    .pb_we     (pb_we),
    .pb_size   (pb_size),
    .pb_addr   (pb_addr),
    .pb_wdata  (pb_wdata),
    .busy      (busy),
    .busy_nxt  (busy_nxt),
    .ev_rd_ok  (ev_rd_ok),
    .ev_err_ack(ev_err_ack),
    .ev_tmo    (ev_tmo)
  );

  rcb_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst),
    .stat_clr    (stat_clr),
    .cmd_go      (cmd_go),
    .cmd_coll    (cmd_coll),
    .cmd_bad     (cmd_bad),
    .cmd_word    (reg_wdata),
    .busy        (busy),
    .busy_nxt    (busy_nxt),
    .ev_rd_ok    (ev_rd_ok),
    .ev_err_ack  (ev_err_ack),
    .ev_tmo      (ev_tmo),
    .pb_rdata    (pb_rdata),
    .grp_a_err   (grp_a_err),
    .grp_b_err   (grp_b_err),
    .status_word (status_word),
    .latched_word(latched_word),
    .cmd_echo    (cmd_echo)
  );

  // R13: unmapped offsets read as zero
  always_comb begin
    if (reg_addr == REG_AW'(OFS_CMD))       reg_rdata = cmd_echo;
    else if (reg_addr == REG_AW'(OFS_STAT)) reg_rdata = status_word;
    else if (reg_addr == REG_AW'(OFS_LAT))  reg_rdata = latched_word;
    else                                    reg_rdata = '0;
  end

  assert_no_start_on_coll_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == REG_AW'(OFS_CMD) && pb_req && !pb_ack && !pb_err_ack && !ev_tmo)
      |=> $stable(cmd_echo));

  assert_bad_size_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == REG_AW'(OFS_CMD) && !pb_req && reg_wdata[62:61] == 2'b10)
      |=> (!pb_req && status_word[32+BIT_BADSZ]));
endmodule

// File: tb/regcmd_pbus_bridge_tb.sv
module regcmd_pbus_bridge_tb;
  localparam int TO = 16;
  localparam logic [2:0] A_CMD = 3'd0, A_STAT = 3'd1, A_LAT = 3'd2, A_RST = 3'd4;
  localparam logic [31:0] M_BUS = 32'h7FEC_0000, M_EACK = 32'h0010_0000;
  localparam logic [31:0] M_GA = 32'h0000_FC00, M_GB = 32'h0000_00FC;
  localparam logic [63:0] GO = 64'h8000_0000_0000_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic        pb_req, pb_we;
  logic [1:0]  pb_size;
  logic [23:0] pb_addr;
  logic [31:0] pb_wdata;
  logic        pb_ack = 1'b0, pb_err_ack = 1'b0;
  logic [31:0] pb_rdata = '0;
  logic [5:0]  grp_a_err = '0, grp_b_err = '0;

  int total = 0, bad = 0;
  logic [31:0] m_err = '0, m_rd = '0;
  logic        m_rv = 1'b0, m_held = 1'b0;
  logic [63:0] m_lat = '0, m_cmd = '0;

  regcmd_pbus_bridge #(.REG_AW(3), .TIMEOUT_CYCLES(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pb_req(pb_req), .pb_we(pb_we),
    .pb_size(pb_size), .pb_addr(pb_addr), .pb_wdata(pb_wdata), .pb_ack(pb_ack),
    .pb_err_ack(pb_err_ack), .pb_rdata(pb_rdata), .grp_a_err(grp_a_err),
    .grp_b_err(grp_b_err)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] stat_of(input logic [31:0] e, input logic rv,
                                          input logic bz, input logic [31:0] rd);
    logic [31:0] hi;
    hi = e;
    hi[17] = rv;
    hi[16] = bz;
    hi[31] = ((e & (M_BUS | M_EACK | M_GA | M_GB)) != 32'h0);
    return {hi, rd};
  endfunction

  task automatic note_fail(input logic bz);
    if (!m_held) begin
      m_lat  = stat_of(m_err, m_rv, bz, m_rd);
      m_held = 1'b1;
    end
  endtask

  task automatic model_clear();
    m_err = '0; m_rv = 1'b0; m_rd = '0; m_lat = '0; m_held = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [63:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic check_regs(input string tag, input logic bz);
    logic [63:0] v;
    rdreg(A_STAT, v); chk({tag, " status"}, v, stat_of(m_err, m_rv, bz, m_rd));
    rdreg(A_LAT, v);  chk({tag, " latched"}, v, m_lat);
    rdreg(A_CMD, v);  chk({tag, " cmd readback"}, v, m_cmd);
  endtask

  function automatic logic [63:0] mk_cmd(input logic we, input logic [1:0] sz,
                                         input logic [23:0] ad, input logic [31:0] d);
    return {we, sz, 5'b0, ad, d};
  endfunction

  // kind: 0 = ack, 1 = error-ack, 2 = no answer (timeout)
  task automatic do_xact(input string tag, input logic we, input logic [1:0] sz,
                         input logic [23:0] ad, input logic [31:0] d, input int dly,
                         input int kind, input logic [31:0] rdat);
    logic [63:0] cmd;
    int n;
    cmd = mk_cmd(we, sz, ad, d);
    wr(A_CMD, cmd);
    m_rv = 1'b0; m_cmd = cmd;
    chk({tag, " R2 req"}, {63'b0, pb_req}, 64'd1);
    chk({tag, " R2 fields"}, {37'b0, pb_we, pb_size, pb_addr}, {37'b0, we, sz, ad});
    if (we) chk({tag, " R2 wdata"}, {32'b0, pb_wdata}, {32'b0, d});
    if (kind == 2) begin
      n = 0;
      while (pb_req === 1'b1 && n < 100) begin
        n++;
        @(negedge clk);
      end
      chk({tag, " R6 request cycles"}, 64'(n), 64'(TO));
      m_err = m_err | 32'h0008_0000;
      note_fail(1'b0);
    end else begin
      check_regs({tag, " R3 busy"}, 1'b1);
      repeat (dly) @(negedge clk);
      chk({tag, " R3 still requesting"}, {63'b0, pb_req}, 64'd1);
      if (kind == 0) pb_ack = 1'b1; else pb_err_ack = 1'b1;
      pb_rdata = rdat;
      @(negedge clk);
      pb_ack = 1'b0; pb_err_ack = 1'b0;
      chk({tag, " R3 req dropped"}, {63'b0, pb_req}, 64'd0);
      if (kind == 0) begin
        if (!we) begin m_rv = 1'b1; m_rd = rdat; end
      end else begin
        m_err = m_err | 32'h0010_0000;
        note_fail(1'b0);
      end
    end
    check_regs({tag, (kind == 1) ? " R5" : (kind == 2) ? " R6" : " R4"}, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [1:0] sz;
    logic [5:0] ga, gb;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_regs("R1 reset", 1'b0);
    chk("R1 req low", {63'b0, pb_req}, 64'd0);

    // R8 illegal size code 10
    wr(A_CMD, mk_cmd(1'b1, 2'b10, 24'h00_1234, 32'hDEAD_BEEF));
    chk("R8 no request", {63'b0, pb_req}, 64'd0);
    m_err = m_err | 32'h0020_0000; note_fail(1'b0);
    check_regs("R8", 1'b0);

    // R7 collision; R10 snapshot must keep the R8 value
    wr(A_CMD, mk_cmd(1'b0, 2'b11, 24'hA5_0010, 32'h0));
    m_cmd = mk_cmd(1'b0, 2'b11, 24'hA5_0010, 32'h0); m_rv = 1'b0;
    wr(A_CMD, mk_cmd(1'b1, 2'b01, 24'h11_2222, 32'h3333_4444));
    chk("R7 request kept", {39'b0, pb_req, pb_addr}, {39'b0, 1'b1, 24'hA5_0010});
    chk("R7 direction kept", {63'b0, pb_we}, 64'd0);
    m_err = m_err | 32'h0004_0000; note_fail(1'b1);
    check_regs("R7 R10", 1'b1);
    pb_ack = 1'b1; pb_rdata = 32'hCAFE_0001;
    @(negedge clk);
    pb_ack = 1'b0;
    m_rv = 1'b1; m_rd = 32'hCAFE_0001;
    check_regs("R7 R4 completion", 1'b0);

    // R11 clear without and with bit 63
    wr(A_STAT, 64'h7FFF_FFFF_FFFF_FFFF);
    check_regs("R11 no-op clear", 1'b0);
    wr(A_STAT, GO);
    model_clear();
    check_regs("R11 clear", 1'b0);

    // R10 fresh snapshot after clear, from an error-ack
    do_xact("R5 R10", 1'b0, 2'b00, 24'h00_0004, 32'h0, 2, 1, 32'h1);
    do_xact("R10 later timeout", 1'b1, 2'b11, 24'h00_0008, 32'h5, 0, 2, 32'h0);

    // R4 write completion leaves read data alone
    wr(A_STAT, GO); model_clear(); check_regs("R11 clear2", 1'b0);
    do_xact("R4 read", 1'b0, 2'b11, 24'h00_0100, 32'h0, 1, 0, 32'h1357_9BDF);
    do_xact("R4 write", 1'b1, 2'b01, 24'h00_0104, 32'h2468_ACE0, 0, 0, 32'hFFFF_FFFF);

    // R9 downstream group errors
    @(negedge clk); grp_a_err = 6'b100001; grp_b_err = 6'b010000;
    @(negedge clk); grp_a_err = '0; grp_b_err = '0;
    m_err = m_err | (32'(6'b100001) << 10) | (32'(6'b010000) << 2);
    check_regs("R9", 1'b0);

    // R13 unmapped read and ignored writes
    rdreg(3'd3, v); chk("R13 unmapped read", v, 64'h0);
    wr(A_LAT, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(3'd6, 64'hFFFF_FFFF_FFFF_FFFF);
    check_regs("R13 ignored writes", 1'b0);

    // R12 soft reset without / with bit 63
    wr(A_RST, 64'h7FFF_FFFF_FFFF_FFFF);
    check_regs("R12 no-op reset", 1'b0);
    wr(A_CMD, mk_cmd(1'b0, 2'b11, 24'h00_0200, 32'h0));
    wr(A_RST, GO);
    chk("R12 req aborted", {63'b0, pb_req}, 64'd0);
    model_clear(); m_cmd = '0;
    check_regs("R12 after reset", 1'b0);
    pb_ack = 1'b1; pb_rdata = 32'h7777_7777;
    @(negedge clk);
    pb_ack = 1'b0;
    check_regs("R12 stray ack", 1'b0);

    // randomized mix (R2 R3 R4 R5 R9 R11)
    for (int i = 0; i < 60; i++) begin
      case ($urandom % 3)
        0: sz = 2'b00;
        1: sz = 2'b01;
        default: sz = 2'b11;
      endcase
      do_xact("rand", 1'($urandom), sz, 24'($urandom), $urandom, int'($urandom % 6),
              ($urandom % 6 == 0) ? 1 : 0, $urandom);
      if (i % 7 == 3) begin
        ga = 6'($urandom); gb = 6'($urandom);
        @(negedge clk); grp_a_err = ga; grp_b_err = gb;
        @(negedge clk); grp_a_err = '0; grp_b_err = '0;
        m_err = m_err | (32'(ga) << 10) | (32'(gb) << 2);
        check_regs("rand R9", 1'b0);
      end
      if (i % 10 == 9) begin
        wr(A_STAT, GO); model_clear();
        check_regs("rand R11", 1'b0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule